// File: doc/BRIEF.md
# Multi-Master Crossbar Slave Arbiter

This block is the routing and arbitration core of an on-chip bus crossbar with four master ports and three slave ports, 32-bit addresses and 32-bit data. Each master presents a request, an address, a write flag, write data, a high-priority flag and a transaction-done strobe. The block decodes every request into one of three address regions: code flash, SRAM and the peripheral bridge. It then routes the request to the matching slave port. The slave's ready and read data are returned to the master that owns that port.

Every slave port has its own arbiter. While the port is free, the arbiter selects one requester in the same cycle. Masters that raise the high-priority flag are considered first. Within the chosen group, a round-robin order starts at the master after the one most recently granted on that port. Once a master owns a port it keeps it until it pulses transaction-done, and the other requesters of that port stall. Masters that target different slaves proceed in parallel. An address outside all three regions completes at once with zero read data.

Top module: `xbar_top`

## Requirements
- R1: Decode regions map addresses to slave indices: 0x0000_0000–0x00FF_FFFF to slave 0 (flash), 0x4000_0000–0x4000_FFFF to slave 1 (SRAM), and 0xC000_0000–0xFFFF_FFFF to slave 2 (peripheral). A lone request to a region raises only that slave's select bit and carries its address to that slave.
- R2: A request to any other address raises no slave select and no stall. In the same cycle it returns ready high and read data zero.
- R3: A slave port is granted to at most one master at a time. When several masters request one slave, exactly one of them is unstalled. Every other requester of that slave has its stall bit high and its ready bit low.
- R4: A granted master that has not pulsed done keeps the port on the next cycle, even when another master raises its high-priority flag. All other requesters of the port stay stalled.
- R5: In the cycle after the owner asserts done, a waiting requester of that port is granted, and its stall bit is low.
- R6: Among the candidate requesters, the winner is the first in the order last+1, last+2, … (modulo 4), where last is the master most recently granted that port. After reset last is master 3, so master 0 wins first.
- R7: When any requester of a port has its high-priority flag set, only high-priority requesters are candidates, and round-robin order applies among them.
- R8: Masters that request different slaves are granted in the same cycle. Each master gets the ready and read data of its own slave.
- R9: A slave port's address, write flag and write data are those of its current owner. The owner's ready and read data are the port's ready and read data.
- R10: Cycles with no request to a port leave that port's round-robin position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | NM | Per-master request |
| m_hipri | input | NM | Per-master priority elevation |
| m_wr | input | NM | Per-master write flag |
| m_done | input | NM | Per-master transaction-done strobe |
| m_addr | input | NM*32 | Master addresses, master i at bits i*32 |
| m_wdata | input | NM*DW | Master write data |
| m_stall | output | NM | Master waits for arbitration |
| m_ready | output | NM | Master's access is answered this cycle |
| m_rdata | output | NM*DW | Read data to each master |
| s_sel | output | 3 | Slave port in use |
| s_wr | output | 3 | Write flag to each slave |
| s_addr | output | 3*32 | Address to each slave |
| s_wdata | output | 3*DW | Write data to each slave |
| s_ready | input | 3 | Slave ready |
| s_rdata | input | 3*DW | Slave read data |

## Verification
A wrong owner register shows at once as a stall vector with two or zero open requesters on one slave port. It also shows as a slave address that belongs to a master that lost. A lost or mis-set lock shows in the cycle after a grant, when a waiting master is let through before the owner's done. A corrupted round-robin pointer shows only at the next contention on that port, because the winner then differs from the one that follows the last grant. The bench therefore sweeps every requester and priority combination back to back, so a pointer error surfaces within one cycle.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int XB_AW     = 32;
    localparam int XB_SLAVES = 3;

    typedef enum logic [1:0] {
        SL_FLASH  = 2'd0,
        SL_SRAM   = 2'd1,
        SL_PERIPH = 2'd2
    } slave_e;

    typedef struct packed {
        logic   hit;
        slave_e dst;
    } route_t;

    function automatic route_t decode_addr(input logic [XB_AW-1:0] a);
        route_t r;
        r.hit = 1'b0;
        r.dst = SL_FLASH;
        if (a[31:24] == 8'h00) begin
            r.hit = 1'b1;
            r.dst = SL_FLASH;
        end else if (a[31:16] == 16'h4000) begin
            r.hit = 1'b1;
            r.dst = SL_SRAM;
        end else if (a[31:30] == 2'b11) begin
            r.hit = 1'b1;
            r.dst = SL_PERIPH;
        end
        return r;
    endfunction

endpackage

// File: rtl/xbar_decode.sv
module xbar_decode
    import xbar_pkg::*;
(
    input  logic [XB_AW-1:0] addr,
    output route_t           route
);
    always_comb route = decode_addr(addr);
endmodule

// File: rtl/xbar_port_arb.sv
module xbar_port_arb #(
    parameter int NM = 4,
    localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NM-1:0] req,
    input  logic [NM-1:0] hipri,
    input  logic [NM-1:0] done,
    output logic [NM-1:0] gnt,
    output logic          gnt_vld,
    output logic [IW-1:0] gnt_id
);
    logic          busy_q;
    logic [IW-1:0] owner_q;
    logic [IW-1:0] ptr_q;

    logic [NM-1:0] cand;
    logic          found;
    logic [IW-1:0] win;

    // candidate set: elevated requesters first, otherwise all requesters
    always_comb begin
        cand  = (|(req & hipri)) ? (req & hipri) : req;
        found = 1'b0;
        win   = '0;
        for (int i = 1; i <= NM; i++) begin
            if (!found && cand[(int'(ptr_q) + i) % NM]) begin
                found = 1'b1;
                win   = IW'((int'(ptr_q) + i) % NM);
            end
        end
    end

    always_comb begin
        gnt_vld = busy_q | found;
        gnt_id  = busy_q ? owner_q : win;
        gnt     = gnt_vld ? (NM'(1) << gnt_id) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            owner_q <= '0;
            ptr_q   <= IW'(NM - 1);
        end else if (busy_q) begin
            if (done[owner_q]) busy_q <= 1'b0;
        end else if (found) begin
            ptr_q <= win;
            if (!done[win]) begin
                busy_q  <= 1'b1;
                owner_q <= win;
            end
        end
    end
endmodule

// File: rtl/xbar_slave_mux.sv
module xbar_slave_mux #(
    parameter int NM = 4,
    parameter int AW = 32,
    parameter int DW = 32,
    localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic           gnt_vld,
    input  logic [IW-1:0]  gnt_id,
    input  logic [NM*AW-1:0] m_addr,
    input  logic [NM-1:0]  m_wr,
    input  logic [NM*DW-1:0] m_wdata,
    output logic           sel,
    output logic           wr,
    output logic [AW-1:0]  addr,
    output logic [DW-1:0]  wdata
);
    always_comb begin
        sel   = gnt_vld;
        wr    = gnt_vld ? m_wr[gnt_id] : 1'b0;
        addr  = gnt_vld ? m_addr[gnt_id*AW +: AW] : '0;
        wdata = gnt_vld ? m_wdata[gnt_id*DW +: DW] : '0;
    end
endmodule

// File: rtl/xbar_top.sv
module xbar_top
    import xbar_pkg::*;
#(
    parameter int NM = 4,
    parameter int DW = 32,
    localparam int NS = XB_SLAVES,
    localparam int AW = XB_AW,
    localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NM-1:0]    m_req,
    input  logic [NM-1:0]    m_hipri,
    input  logic [NM-1:0]    m_wr,
    input  logic [NM-1:0]    m_done,
    input  logic [NM*AW-1:0] m_addr,
    input  logic [NM*DW-1:0] m_wdata,
    output logic [NM-1:0]    m_stall,
    output logic [NM-1:0]    m_ready,
    output logic [NM*DW-1:0] m_rdata,
    output logic [NS-1:0]    s_sel,
    output logic [NS-1:0]    s_wr,
    output logic [NS*AW-1:0] s_addr,
    output logic [NS*DW-1:0] s_wdata,
    input  logic [NS-1:0]    s_ready,
    input  logic [NS*DW-1:0] s_rdata
);
    route_t        route [NM];
    logic [NM-1:0] sreq  [NS];
    logic [NM-1:0] gnt_v [NS];
    logic          gvld  [NS];
    logic [IW-1:0] gid   [NS];
    logic [NS*NM-1:0] gnt_flat;

    for (genvar m = 0; m < NM; m++) begin : g_dec
        xbar_decode i_dec (
            .addr  (m_addr[m*AW +: AW]),
            .route (route[m])
        );
    end

    always_comb begin
        for (int s = 0; s < NS; s++) begin
            for (int m = 0; m < NM; m++) begin
                sreq[s][m] = m_req[m] & route[m].hit & (int'(route[m].dst) == s);
            end
        end
    end

    for (genvar s = 0; s < NS; s++) begin : g_slv
        xbar_port_arb #(.NM(NM)) i_arb (
            .clk     (clk),
            .rst     (rst),
            .req     (sreq[s]),
            .hipri   (m_hipri),
            .done    (m_done),
            .gnt     (gnt_v[s]),
            .gnt_vld (gvld[s]),
            .gnt_id  (gid[s])
        );
        xbar_slave_mux #(.NM(NM), .AW(AW), .DW(DW)) i_mux (
            .gnt_vld (gvld[s]),
            .gnt_id  (gid[s]),
            .m_addr  (m_addr),
            .m_wr    (m_wr),
            .m_wdata (m_wdata),
            .sel     (s_sel[s]),
            .wr      (s_wr[s]),
            .addr    (s_addr[s*AW +: AW]),
            .wdata   (s_wdata[s*DW +: DW])
        );
        assign gnt_flat[s*NM +: NM] = gnt_v[s];
    end

    // return path: each master sees the slave it owns
    always_comb begin
        for (int m = 0; m < NM; m++) begin
            logic          owns;
            logic          rdy;
            logic [DW-1:0] rd;
            owns = 1'b0;
            rdy  = 1'b0;
            rd   = '0;
            for (int s = 0; s < NS; s++) begin
                if (gnt_v[s][m] && route[m].hit && int'(route[m].dst) == s) begin
                    owns = 1'b1;
                    rdy  = s_ready[s];
                    rd   = s_rdata[s*DW +: DW];
                end
            end
            m_stall[m]           = m_req[m] & route[m].hit & ~owns;
            m_ready[m]           = m_req[m] & (route[m].hit ? (owns & rdy) : 1'b1);
            m_rdata[m*DW +: DW]  = (m_req[m] && route[m].hit && owns) ? rd : '0;
        end
    end
endmodule

// File: rtl/xbar_chk.sv
module xbar_chk
    import xbar_pkg::*;
#(
    parameter int NM = 4,
    parameter int NS = 3,
    parameter int DW = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [NM-1:0]    m_req,
    input logic [NM-1:0]    m_done,
    input logic [NM*XB_AW-1:0] m_addr,
    input logic [NM-1:0]    m_stall,
    input logic [NM-1:0]    m_ready,
    input logic [NM*DW-1:0] m_rdata,
    input logic [NS*XB_AW-1:0] s_addr,
    input logic [NS*NM-1:0] gnt_flat
);
    for (genvar s = 0; s < NS; s++) begin : g_s
        // R3
        single_owner_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(gnt_flat[s*NM +: NM]));
        for (genvar m = 0; m < NM; m++) begin : g_m
            // R4
            grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (gnt_flat[s*NM+m] && !m_done[m]) |=> gnt_flat[s*NM+m]);
            // R9
            addr_route_chk: assert property (@(posedge clk) disable iff (rst)
                gnt_flat[s*NM+m] |-> (s_addr[s*XB_AW +: XB_AW] == m_addr[m*XB_AW +: XB_AW]));
        end
    end

    for (genvar m = 0; m < NM; m++) begin : g_mm
        // R3
        stall_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
            m_stall[m] |-> !m_ready[m]);
        // R2
        unmapped_done_chk: assert property (@(posedge clk) disable iff (rst)
            (m_req[m] && !decode_addr(m_addr[m*XB_AW +: XB_AW]).hit)
                |-> (m_ready[m] && m_rdata[m*DW +: DW] == '0 && !m_stall[m]));
    end
endmodule

bind xbar_top xbar_chk #(.NM(NM), .NS(NS), .DW(DW)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .m_req    (m_req),
    .m_done   (m_done),
    .m_addr   (m_addr),
    .m_stall  (m_stall),
    .m_ready  (m_ready),
    .m_rdata  (m_rdata),
    .s_addr   (s_addr),
    .gnt_flat (gnt_flat)
);

// File: tb/test_xbar_top.sv
module test_xbar_top;
    localparam int NM = 4;
    localparam int NS = 3;
    localparam int DW = 32;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NM-1:0]    m_req = '0, m_hipri = '0, m_wr = '0, m_done = '0;
    logic [NM*AW-1:0] m_addr = '0;
    logic [NM*DW-1:0] m_wdata = '0;
    logic [NM-1:0]    m_stall, m_ready;
    logic [NM*DW-1:0] m_rdata;
    logic [NS-1:0]    s_sel, s_wr;
    logic [NS*AW-1:0] s_addr;
    logic [NS*DW-1:0] s_wdata;
    logic [NS-1:0]    s_ready = '1;
    logic [NS*DW-1:0] s_rdata = {32'hC0DE_0002, 32'hC0DE_0001, 32'hC0DE_0000};

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    xbar_top #(.NM(NM), .DW(DW)) i_xbar_top (
        .clk(clk), .rst(rst), .m_req(m_req), .m_hipri(m_hipri), .m_wr(m_wr),
        .m_done(m_done), .m_addr(m_addr), .m_wdata(m_wdata), .m_stall(m_stall),
        .m_ready(m_ready), .m_rdata(m_rdata), .s_sel(s_sel), .s_wr(s_wr),
        .s_addr(s_addr), .s_wdata(s_wdata), .s_ready(s_ready), .s_rdata(s_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected region: -1 unmapped, else slave index
    function automatic int region(input logic [31:0] a);
        if (a <= 32'h00FF_FFFF) return 0;
        if (a >= 32'h4000_0000 && a <= 32'h4000_FFFF) return 1;
        if (a >= 32'hC000_0000) return 2;
        return -1;
    endfunction

    function automatic int pick(input logic [3:0] req, input logic [3:0] hp, input int last);
        logic [3:0] c;
        c = (|(req & hp)) ? (req & hp) : req;
        for (int i = 1; i <= 4; i++) if (c[(last + i) % 4]) return (last + i) % 4;
        return -1;
    endfunction

    task automatic drive_edge();
        @(posedge clk); #1;
    endtask

    task automatic sample();
        @(negedge clk);
    endtask

    task automatic clear_in();
        m_req = '0; m_hipri = '0; m_wr = '0; m_done = '0; m_addr = '0; m_wdata = '0;
        s_ready = '1;
    endtask

    task automatic do_reset();
        clear_in();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic set_m(input int m, input logic [31:0] a, input logic w, input logic [31:0] d);
        m_req[m] = 1'b1;
        m_addr[m*AW +: AW] = a;
        m_wr[m] = w;
        m_wdata[m*DW +: DW] = d;
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] addrs [10];
        int last;
        addrs = '{32'h0000_1234, 32'h00FF_FFFC, 32'h4000_0010, 32'h4000_FFFC, 32'hC000_0000,
                  32'hFFFF_FFF0, 32'h0100_0000, 32'h3FFF_FFFF, 32'h4001_0000, 32'hBFFF_FFFF};

        do_reset();
        sample();
        // reset state
        chk(s_sel == '0,   "reset s_sel",   32'(s_sel),   0);
        chk(m_stall == '0, "reset m_stall", 32'(m_stall), 0);
        chk(m_ready == '0, "reset m_ready", 32'(m_ready), 0);

        // R1 / R2 decode sweep, single-cycle transactions
        for (int m = 0; m < NM; m++) begin
            for (int k = 0; k < 10; k++) begin
                int r;
                drive_edge();
                clear_in();
                set_m(m, addrs[k], 1'b0, 32'h0);
                m_done[m] = 1'b1;
                r = region(addrs[k]);
                sample();
                if (r < 0) begin
                    chk(s_sel == '0, "R2 no select", 32'(s_sel), 0);
                    chk(m_ready[m] && m_rdata[m*DW +: DW] == 0 && !m_stall[m], "R2 unmapped ready/zero",
                        m_rdata[m*DW +: DW], 0);
                end else begin
                    chk(s_sel == 3'(1 << r), "R1 select", 32'(s_sel), 32'(1 << r));
                    chk(s_addr[r*AW +: AW] == addrs[k], "R1 address", s_addr[r*AW +: AW], addrs[k]);
                    chk(m_ready[m] && m_rdata[m*DW +: DW] == 32'hC0DE_0000 + 32'(r), "R9 read data",
                        m_rdata[m*DW +: DW], 32'hC0DE_0000 + 32'(r));
                end
            end
        end

        // R6 / R7 exhaustive requester x priority sweep on flash
        do_reset();
        last = 3;
        for (int mask = 1; mask < 16; mask++) begin
            for (int hp = 0; hp < 16; hp++) begin
                int w;
                clear_in();
                for (int m = 0; m < NM; m++) if (mask[m]) set_m(m, 32'h100 * m, 1'b0, 0);
                m_hipri = 4'(hp);
                m_done  = 4'(mask);
                w = pick(4'(mask), 4'(hp), last);
                sample();
                chk(m_stall == (4'(mask) & ~4'(1 << w)),
                    ((mask & hp) != 0) ? "R7 priority winner" : "R6 round-robin winner",
                    32'(m_stall), 32'(4'(mask) & ~4'(1 << w)));
                chk(s_addr[AW-1:0] == 32'h100 * w, "R3 single owner address", s_addr[AW-1:0], 32'h100 * w);
                last = w;
                drive_edge();
            end
        end

        // R4 / R5 hold and hand-over on SRAM
        do_reset();
        set_m(0, 32'h4000_0100, 1'b1, 32'h1111_0000);
        set_m(2, 32'h4000_0200, 1'b0, 32'h2222_0000);
        sample();
        chk(m_stall == 4'b0100, "R6 first winner master 0", 32'(m_stall), 32'h4);
        chk(s_wr[1] && s_wdata[DW +: DW] == 32'h1111_0000, "R9 write path", s_wdata[DW +: DW], 32'h1111_0000);
        drive_edge();
        m_hipri[2] = 1'b1;
        for (int c = 0; c < 3; c++) begin
            sample();
            chk(m_stall == 4'b0100, "R4 hold over priority", 32'(m_stall), 32'h4);
            drive_edge();
        end
        m_done[0] = 1'b1;
        sample();
        chk(m_stall == 4'b0100 && m_ready[0], "R4 owner still holds on done", 32'(m_stall), 32'h4);
        drive_edge();
        m_req[0] = 1'b0; m_done[0] = 1'b0;
        sample();
        chk(m_stall == 4'b0000 && s_addr[AW +: AW] == 32'h4000_0200, "R5 hand-over next cycle",
            s_addr[AW +: AW], 32'h4000_0200);
        drive_edge();
        m_done[2] = 1'b1;
        drive_edge();
        clear_in();

        // R10 idle keeps position (last SRAM grant = master 2)
        repeat (5) drive_edge();
        set_m(0, 32'h4000_0000, 1'b0, 0);
        set_m(3, 32'h4000_0004, 1'b0, 0);
        sample();
        chk(m_stall == 4'b0001, "R10 pointer kept over idle", 32'(m_stall), 32'h1);
        drive_edge();
        m_done[3] = 1'b1;
        drive_edge();
        clear_in();

        // R8 concurrent masters on different slaves
        do_reset();
        s_ready = 3'b001;
        set_m(1, 32'h0000_0040, 1'b0, 0);
        set_m(3, 32'hC000_0008, 1'b1, 32'h3333_0000);
        sample();
        chk(m_stall == '0 && s_sel == 3'b101, "R8 both granted", 32'(s_sel), 32'h5);
        chk(m_ready[1] && m_rdata[DW +: DW] == 32'hC0DE_0000, "R8 flash data to master 1",
            m_rdata[DW +: DW], 32'hC0DE_0000);
        chk(!m_ready[3] && s_wr[2] && s_wdata[2*DW +: DW] == 32'h3333_0000, "R9 periph write not ready",
            s_wdata[2*DW +: DW], 32'h3333_0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule